// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a chip through its power modes: fully off, deep sleep (only the always-on RTC domain powered), light sleep (main domain powered, crystal stopped), a wake-up phase that restarts the crystal oscillator and PLLs and waits for them to settle, and the running state. It runs on the always-on slow clock and drives the enables for the RTC domain, main-domain power, the crystal oscillator, the PLLs, a vector of per-block clock gates and the CPU clock gate.

In the running state, firmware writes two configuration registers. The first is a clock-gate mask that picks which blocks receive the high-speed clock. The second is the crystal-settle length in slow-clock cycles. A sleep request or a deep-sleep request moves the controller into a one-cycle drain state and from there into the chosen sleep mode. A wake event that arrives during the drain cycle sends the controller straight back to wake-up. A wait-for-interrupt request stops only the CPU clock, and any interrupt or wake event opens it again. When the chip-enable pin is low, everything is held off and both registers return to their defaults.

Top module: `pwrseq_top`

## Requirements
- R1: While `chip_en_i` is low, the state becomes OFF (code 0) at the next clock edge. In OFF, every enable output and every clock-gate output is 0.
- R2: While `chip_en_i` is low, the clock-gate mask returns to all ones and the settle length returns to 8 cycles.
- R3: State codes are DEEP=1, SLEEP=2, DRAIN=3, WAKE=4, ON=5. `rtc_en_o` is 1 in every state except OFF. `main_pwr_o` is 1 in every state except OFF and DEEP. `xtal_en_o` and `pll_en_o` are 1 only in DRAIN, WAKE and ON.
- R4: The controller enters WAKE from OFF when `chip_en_i` is high. It stays in WAKE for exactly N clock cycles, where N is the settle length (a value of 0 counts as 1), and then enters ON.
- R5: In ON, `blk_clk_en_o` equals the clock-gate mask. In every other state it is 0. A write with `cfg_sel_i`=0 loads the mask from the low bits of `cfg_wdata_i`. A write with `cfg_sel_i`=1 loads the settle length. A write takes effect on the next cycle.
- R6: A configuration write is ignored unless the state is ON.
- R7: In ON, `deep_req_i` moves the controller to DRAIN and then to DEEP. `sleep_req_i` alone moves it to DRAIN and then to SLEEP. If both requests are present, the deep request wins.
- R8: SLEEP leaves for WAKE on any of the MAC, host, timer or external wake inputs. DEEP leaves only on the timer or external inputs and ignores the MAC and host inputs.
- R9: A wake event that is valid for the target sleep mode and is present during DRAIN sends the controller directly to WAKE.
- R10: In ON, `wfi_req_i` makes `cpu_clk_en_o` go to 0 from the next cycle. It stays 0 until `irq_i` or any wake input is seen. `cpu_clk_en_o` is 0 outside ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable; low forces OFF and clears registers |
| sleep_req_i | input | 1 | Sleep criteria met (light sleep request) |
| deep_req_i | input | 1 | Deep-sleep request |
| wake_mac_i | input | 1 | Wake event from the MAC |
| wake_host_i | input | 1 | Wake event from the host |
| wake_timer_i | input | 1 | Wake event from the RTC timer |
| wake_ext_i | input | 1 | External wake pin or interrupt |
| wfi_req_i | input | 1 | CPU wait-for-interrupt request |
| irq_i | input | 1 | Any enabled CPU interrupt |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: clock-gate mask, 1: settle length |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| state_o | output | 3 | Current state code |
| rtc_en_o | output | 1 | RTC domain enable |
| main_pwr_o | output | 1 | Main-domain power enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| blk_clk_en_o | output | NBLK | Per-block high-speed clock enables |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The bench times the wake-up phase cycle by cycle, both with the default settle length and with a programmed one. A design that leaves WAKE one cycle early or late shows up as a state mismatch on the expected ON cycle. It drives MAC and host wake events into deep sleep, where a design with the wrong wake mask would power up. It drops the chip enable after reprogramming, which shows whether the mask and settle length really fall back to their defaults. It also places wake events inside the one-cycle drain window, where a design that loses them would settle into sleep. Configuration writes issued during sleep must leave the mask unchanged, and the CPU gate must hold closed after the wait request is removed and reopen only on an interrupt or wake.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,
        PS_DEEP  = 3'd1,
        PS_SLEEP = 3'd2,
        PS_DRAIN = 3'd3,
        PS_WAKE  = 3'd4,
        PS_ON    = 3'd5
    } pstate_e;

endpackage

// File: rtl/pwrseq_cfg.sv
module pwrseq_cfg #(
    parameter int NBLK       = 8,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 16,
    parameter int SETTLE_RST = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              chip_en_i,
    input  logic              wr_ok_i,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NBLK-1:0]   gate_o,
    output logic [CNT_W-1:0]  settle_o
);

    localparam logic [CNT_W-1:0] SETTLE_DEF = CNT_W'(SETTLE_RST);
    localparam logic [NBLK-1:0]  GATE_DEF   = '1;

    typedef struct packed {
        logic [NBLK-1:0]  gate;
        logic [CNT_W-1:0] settle;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!chip_en_i) begin
            cfg_d.gate   = GATE_DEF;
            cfg_d.settle = SETTLE_DEF;
        end else if (we_i && wr_ok_i) begin
            if (sel_i) begin
                cfg_d.settle = wdata_i[CNT_W-1:0];
            end else begin
                cfg_d.gate = wdata_i[NBLK-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{gate: GATE_DEF, settle: SETTLE_DEF};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign gate_o   = cfg_q.gate;
    assign settle_o = cfg_q.settle;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             chip_en_i,
    input  logic             sleep_req_i,
    input  logic             deep_req_i,
    input  logic             wake_mac_i,
    input  logic             wake_host_i,
    input  logic             wake_timer_i,
    input  logic             wake_ext_i,
    input  logic             wfi_req_i,
    input  logic             irq_i,
    input  logic [CNT_W-1:0] settle_i,
    output pstate_e          state_o,
    output logic             cpu_wait_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        pstate_e          st;
        logic             deep_tgt;
        logic [CNT_W-1:0] cnt;
        logic             cpu_wait;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic any_wake;
    logic rtc_wake;

    assign any_wake = wake_mac_i | wake_host_i | wake_timer_i | wake_ext_i;
    assign rtc_wake = wake_timer_i | wake_ext_i;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            PS_OFF: begin
                fsm_d.st  = PS_WAKE;
                fsm_d.cnt = settle_i;
            end
            PS_DEEP: begin
                if (rtc_wake) begin
                    fsm_d.st  = PS_WAKE;
                    fsm_d.cnt = settle_i;
                end
            end
            PS_SLEEP: begin
                if (any_wake) begin
                    fsm_d.st  = PS_WAKE;
                    fsm_d.cnt = settle_i;
                end
            end
            PS_DRAIN: begin
                if (fsm_q.deep_tgt ? rtc_wake : any_wake) begin
                    fsm_d.st  = PS_WAKE;
                    fsm_d.cnt = settle_i;
                end else begin
                    fsm_d.st = fsm_q.deep_tgt ? PS_DEEP : PS_SLEEP;
                end
            end
            PS_WAKE: begin
                if (fsm_q.cnt <= ONE) begin
                    fsm_d.st = PS_ON;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - ONE;
                end
            end
            PS_ON: begin
                if (deep_req_i) begin
                    fsm_d.st       = PS_DRAIN;
                    fsm_d.deep_tgt = 1'b1;
                end else if (sleep_req_i) begin
                    fsm_d.st       = PS_DRAIN;
                    fsm_d.deep_tgt = 1'b0;
                end
                if (irq_i || any_wake) begin
                    fsm_d.cpu_wait = 1'b0;
                end else if (wfi_req_i) begin
                    fsm_d.cpu_wait = 1'b1;
                end
            end
            default: fsm_d.st = PS_OFF;
        endcase

        if (fsm_d.st != PS_ON) begin
            fsm_d.cpu_wait = 1'b0;
        end

        if (!chip_en_i) begin
            fsm_d = '{st: PS_OFF, deep_tgt: 1'b0, cnt: '0, cpu_wait: 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{st: PS_OFF, deep_tgt: 1'b0, cnt: '0, cpu_wait: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o    = fsm_q.st;
    assign cpu_wait_o = fsm_q.cpu_wait;

endmodule

// File: rtl/pwrseq_out.sv
module pwrseq_out
    import pwrseq_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  pstate_e         state_i,
    input  logic [NBLK-1:0] gate_i,
    input  logic            cpu_wait_i,
    output logic            rtc_en_o,
    output logic            main_pwr_o,
    output logic            xtal_en_o,
    output logic            pll_en_o,
    output logic [NBLK-1:0] blk_clk_en_o,
    output logic            cpu_clk_en_o
);

    logic run;
    logic clk_src;

    assign run     = (state_i == PS_ON);
    assign clk_src = (state_i == PS_DRAIN) || (state_i == PS_WAKE) || run;

    assign rtc_en_o     = (state_i != PS_OFF);
    assign main_pwr_o   = (state_i != PS_OFF) && (state_i != PS_DEEP);
    assign xtal_en_o    = clk_src;
    assign pll_en_o     = clk_src;
    assign cpu_clk_en_o = run && !cpu_wait_i;

    for (genvar b = 0; b < NBLK; b++) begin : g_gate
        assign blk_clk_en_o[b] = run && gate_i[b];
    end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int NBLK       = 8,
    parameter int CNT_W      = 16,
    parameter int SETTLE_RST = 8,
    localparam int DATA_W    = (NBLK > CNT_W) ? NBLK : CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              chip_en_i,
    input  logic              sleep_req_i,
    input  logic              deep_req_i,
    input  logic              wake_mac_i,
    input  logic              wake_host_i,
    input  logic              wake_timer_i,
    input  logic              wake_ext_i,
    input  logic              wfi_req_i,
    input  logic              irq_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [2:0]        state_o,
    output logic              rtc_en_o,
    output logic              main_pwr_o,
    output logic              xtal_en_o,
    output logic              pll_en_o,
    output logic [NBLK-1:0]   blk_clk_en_o,
    output logic              cpu_clk_en_o
);

    pstate_e          st;
    logic             cpu_wait;
    logic [NBLK-1:0]  gate;
    logic [CNT_W-1:0] settle;

    pwrseq_cfg #(
        .NBLK(NBLK), .CNT_W(CNT_W), .DATA_W(DATA_W), .SETTLE_RST(SETTLE_RST)
    ) cfg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .chip_en_i (chip_en_i),
        .wr_ok_i   (st == PS_ON),
        .we_i      (cfg_we_i),
        .sel_i     (cfg_sel_i),
        .wdata_i   (cfg_wdata_i),
        .gate_o    (gate),
        .settle_o  (settle)
    );

    pwrseq_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .chip_en_i    (chip_en_i),
        .sleep_req_i  (sleep_req_i),
        .deep_req_i   (deep_req_i),
        .wake_mac_i   (wake_mac_i),
        .wake_host_i  (wake_host_i),
        .wake_timer_i (wake_timer_i),
        .wake_ext_i   (wake_ext_i),
        .wfi_req_i    (wfi_req_i),
        .irq_i        (irq_i),
        .settle_i     (settle),
        .state_o      (st),
        .cpu_wait_o   (cpu_wait)
    );

    pwrseq_out #(.NBLK(NBLK)) out_i (
        .state_i      (st),
        .gate_i       (gate),
        .cpu_wait_i   (cpu_wait),
        .rtc_en_o     (rtc_en_o),
        .main_pwr_o   (main_pwr_o),
        .xtal_en_o    (xtal_en_o),
        .pll_en_o     (pll_en_o),
        .blk_clk_en_o (blk_clk_en_o),
        .cpu_clk_en_o (cpu_clk_en_o)
    );

    assign state_o = st;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int NBLK = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            chip_en_i,
    input logic            deep_req_i,
    input logic            wake_timer_i,
    input logic            wake_ext_i,
    input logic [2:0]      state_o,
    input logic            xtal_en_o,
    input logic            main_pwr_o,
    input logic [NBLK-1:0] blk_clk_en_o,
    input logic            cpu_clk_en_o
);

    a_r1_off_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chip_en_i |=> (state_o == 3'd0));

    a_r3_deep_powered_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd1) |-> (!xtal_en_o && !main_pwr_o));

    a_r4_wake_exits_to_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4 && chip_en_i) |=> (state_o == 3'd4 || state_o == 3'd5));

    a_r5_gates_closed_off_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != 3'd5) |-> (blk_clk_en_o == '0));

    a_r7_deep_req_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd5 && chip_en_i && deep_req_i) |=> (state_o == 3'd3));

    a_r8_deep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd1 && chip_en_i && !wake_timer_i && !wake_ext_i) |=> (state_o == 3'd1));

    a_r9_drain_wake_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd3 && chip_en_i && (wake_timer_i || wake_ext_i)) |=> (state_o == 3'd4));

    a_r10_cpu_off_outside_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != 3'd5) |-> !cpu_clk_en_o);

endmodule

bind pwrseq_top pwrseq_chk #(.NBLK(NBLK)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chip_en_i    (chip_en_i),
    .deep_req_i   (deep_req_i),
    .wake_timer_i (wake_timer_i),
    .wake_ext_i   (wake_ext_i),
    .state_o      (state_o),
    .xtal_en_o    (xtal_en_o),
    .main_pwr_o   (main_pwr_o),
    .blk_clk_en_o (blk_clk_en_o),
    .cpu_clk_en_o (cpu_clk_en_o)
);

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;

    localparam int NBLK   = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b0;
    logic sleep_req = 1'b0, deep_req = 1'b0;
    logic w_mac = 1'b0, w_host = 1'b0, w_timer = 1'b0, w_ext = 1'b0;
    logic wfi = 1'b0, irq = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [2:0] state;
    logic rtc_en, main_pwr, xtal_en, pll_en, cpu_en;
    logic [NBLK-1:0] blk_en;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [NBLK-1:0] gate_model;

    always #4 clk = ~clk;

    pwrseq_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .chip_en_i(chip_en),
        .sleep_req_i(sleep_req), .deep_req_i(deep_req),
        .wake_mac_i(w_mac), .wake_host_i(w_host), .wake_timer_i(w_timer), .wake_ext_i(w_ext),
        .wfi_req_i(wfi), .irq_i(irq),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .state_o(state), .rtc_en_o(rtc_en), .main_pwr_o(main_pwr),
        .xtal_en_o(xtal_en), .pll_en_o(pll_en),
        .blk_clk_en_o(blk_en), .cpu_clk_en_o(cpu_en)
    );

    typedef struct packed {
        logic [7:0] stim;   // sleep deep mac host timer ext wfi irq
        logic [3:0] ncyc;
        logic [2:0] est;
        logic       ecpu;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t TBL [28] = '{
        '{8'b0000_0010, 4'd1, 3'd5, 1'b0, 4'd10},  // R10 wait closes cpu clock
        '{8'b0000_0000, 4'd2, 3'd5, 1'b0, 4'd10},  // R10 stays closed
        '{8'b0000_0001, 4'd1, 3'd5, 1'b1, 4'd10},  // R10 irq reopens
        '{8'b1000_0000, 4'd1, 3'd3, 1'b0, 4'd7},   // R7 sleep -> drain
        '{8'b0000_0000, 4'd1, 3'd2, 1'b0, 4'd7},   // R7 drain -> sleep
        '{8'b0000_0000, 4'd3, 3'd2, 1'b0, 4'd8},   // R8 sleep holds
        '{8'b0001_0000, 4'd1, 3'd4, 1'b0, 4'd8},   // R8 host wakes sleep
        '{8'b0000_0000, 4'd2, 3'd4, 1'b0, 4'd4},   // R4 settle 3
        '{8'b0000_0000, 4'd1, 3'd5, 1'b1, 4'd4},   // R4 enters on
        '{8'b0100_0000, 4'd1, 3'd3, 1'b0, 4'd7},   // R7 deep -> drain
        '{8'b0000_0000, 4'd1, 3'd1, 1'b0, 4'd7},   // R7 drain -> deep
        '{8'b0001_0000, 4'd2, 3'd1, 1'b0, 4'd8},   // R8 host ignored in deep
        '{8'b0010_0000, 4'd1, 3'd1, 1'b0, 4'd8},   // R8 mac ignored in deep
        '{8'b0000_1000, 4'd1, 3'd4, 1'b0, 4'd8},   // R8 timer wakes deep
        '{8'b0000_0000, 4'd3, 3'd5, 1'b1, 4'd4},   // R4
        '{8'b1000_0000, 4'd1, 3'd3, 1'b0, 4'd7},   // R7
        '{8'b0000_0100, 4'd1, 3'd4, 1'b0, 4'd9},   // R9 ext during drain
        '{8'b0000_0000, 4'd3, 3'd5, 1'b1, 4'd4},   // R4
        '{8'b0100_0000, 4'd1, 3'd3, 1'b0, 4'd7},   // R7
        '{8'b0001_0000, 4'd1, 3'd1, 1'b0, 4'd9},   // R9 host not valid for deep drain
        '{8'b0000_0100, 4'd1, 3'd4, 1'b0, 4'd8},   // R8 ext wakes deep
        '{8'b0000_0000, 4'd3, 3'd5, 1'b1, 4'd4},   // R4
        '{8'b0000_0010, 4'd1, 3'd5, 1'b0, 4'd10},  // R10
        '{8'b0010_0000, 4'd1, 3'd5, 1'b1, 4'd10},  // R10 wake reopens cpu
        '{8'b1100_0000, 4'd1, 3'd3, 1'b0, 4'd7},   // R7 both requests
        '{8'b0000_0000, 4'd1, 3'd1, 1'b0, 4'd7},   // R7 deep wins
        '{8'b0000_1000, 4'd1, 3'd4, 1'b0, 4'd8},   // R8
        '{8'b0000_0000, 4'd3, 3'd5, 1'b1, 4'd4}    // R4
    };

    function automatic logic [3:0] exp_pwr(logic [2:0] st);
        case (st)
            3'd0:    return 4'b0000;
            3'd1:    return 4'b1000;
            3'd2:    return 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_outputs(string req, logic [2:0] est);
        chk(req, "state", 32'(state), 32'(est));
        chk("R3", "power enables", 32'({rtc_en, main_pwr, xtal_en, pll_en}), 32'(exp_pwr(est)));
        chk("R5", "block clocks", 32'(blk_en), (est == 3'd5) ? 32'(gate_model) : 32'd0);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [DATA_W-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic count_wake(string req, int exp_n);
        int n = 0;
        while (state == 3'd4 && n < 100) begin
            n++;
            cyc(1);
        end
        chk(req, "cycles in wake", 32'(n), 32'(exp_n));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        gate_model = '1;
        cyc(3);
        // R1 reset state, chip disabled
        chk_outputs("R1", 3'd0);
        chk("R1", "cpu clock", 32'(cpu_en), 32'd0);
        rst_n = 1'b1;
        cyc(2);
        chk_outputs("R1", 3'd0);

        // R4 boot with default settle of 8
        chip_en = 1'b1;
        cyc(1);
        chk_outputs("R4", 3'd4);
        count_wake("R4", 8);
        chk_outputs("R4", 3'd5);
        chk("R10", "cpu clock", 32'(cpu_en), 32'd1);

        // R5 program gate mask and settle
        wr(1'b0, 16'h00A5);
        gate_model = 8'hA5;
        chk("R5", "block clocks", 32'(blk_en), 32'hA5);
        wr(1'b1, 16'd3);

        // table walk
        for (int i = 0; i < 28; i++) begin
            {sleep_req, deep_req, w_mac, w_host, w_timer, w_ext, wfi, irq} = TBL[i].stim;
            cyc(int'(TBL[i].ncyc));
            chk_outputs($sformatf("R%0d", TBL[i].rq), TBL[i].est);
            chk($sformatf("R%0d", TBL[i].rq), "cpu clock", 32'(cpu_en), 32'(TBL[i].ecpu));
        end
        {sleep_req, deep_req, w_mac, w_host, w_timer, w_ext, wfi, irq} = '0;

        // R6 writes in sleep are ignored
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; cyc(1);
        chk_outputs("R6", 3'd2);
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'd9);
        w_host = 1'b1; cyc(1); w_host = 1'b0;
        chk_outputs("R6", 3'd4);
        count_wake("R6", 3);
        chk_outputs("R6", 3'd5);
        chk("R6", "mask after sleep write", 32'(blk_en), 32'hA5);

        // R1/R2 chip enable drop clears registers
        chip_en = 1'b0; cyc(1);
        chk_outputs("R1", 3'd0);
        chk("R1", "cpu clock", 32'(cpu_en), 32'd0);
        w_timer = 1'b1; cyc(2); w_timer = 1'b0;
        chk_outputs("R1", 3'd0);
        chip_en = 1'b1; cyc(1);
        gate_model = '1;
        chk_outputs("R2", 3'd4);
        count_wake("R2", 8);
        chk_outputs("R2", 3'd5);
        chk("R2", "mask default", 32'(blk_en), 32'hFF);

        // R4 settle of 0 acts as 1
        wr(1'b1, 16'd0);
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; cyc(1);
        w_mac = 1'b1; cyc(1); w_mac = 1'b0;
        chk_outputs("R4", 3'd4);
        count_wake("R4", 1);
        chk_outputs("R4", 3'd5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule